// File: doc/BRIEF.md
# Legacy Controller Shadow Readback Unit

This block sits beside a cascaded pair of priority interrupt controllers and a three-channel interval timer on a 16-bit I/O bus. Many of the settings those controllers accept cannot be read back. Examples are the trigger style, the nesting and end-of-interrupt options, the vector base, the pending poll and register-select choices, and the timers' programmed base counts. The unit snoops every CPU write to those controllers, decodes the setup and command sequences itself, and keeps copies of the selected fields.

When the shadow-enable input is high, a read at one of the shadow ports is claimed through a combinational `shadow_hit`. The bus mux then takes `shadow_rdata` in place of the live controller register. Writes always reach the real controllers unchanged, and the snooping carries on whether or not readback is enabled. When shadow-enable is low the unit never claims a read.

Top module: `legacy_shadow_unit`

## Requirements
- R1: The upper eleven address bits select a target: 0x001 is the master interrupt controller, 0x005 is the slave, and 0x002 is the timer. Address bits 4:1 (interrupt controllers) and 4:2 (timer) are ignored. `shadow_hit` is high in the same cycle as `io_rd` only when `shadow_en` is 1 and the address selects an interrupt controller port or timer counter 0, 1 or 2. It is never high for the timer command port (bits 1:0 = 3), for any other address, or when `shadow_en` is 0. `shadow_rdata` is 0 whenever `shadow_hit` is low.
- R2: Writes are captured the same way whether `shadow_en` is 0 or 1.
- R3: A read of an interrupt controller's even port returns the control byte. Bit 7 is 0, bit 6 is poll, bit 5 is read-select, bit 4 is special-mask, bit 3 is rotate, bit 2 is special-fully-nested, bit 1 is auto-EOI, and bit 0 is level-trigger.
- R4: An even-port write with data bit 4 set is a setup word. It stores level-trigger from data bit 3, and remembers single-mode (bit 1) and a fourth-word flag (bit 0). The next odd-port write stores data bits 7:3 as vector bits, which read back in bits 4:0 of the odd port with bits 7:5 zero. A cascade word follows only if single-mode was 0. A fourth word follows only if the flag was 1, and it stores auto-EOI from bit 1 and special-fully-nested from bit 4.
- R5: An even-port write with bit 4 clear and bit 3 clear stores rotate from bit 7. With bit 4 clear and bit 3 set, it stores poll from bit 2 and read-select from bit 0 on every write, and stores special-mask from bit 5 only when bit 6 is 1.
- R6: Odd-port writes outside a setup sequence leave that controller's shadow bytes unchanged.
- R7: A timer command write selects a counter with data bits 7:6 (3 selects none) and an access mode with bits 5:4. Mode 1 is low byte only, 2 is high byte only, 3 is low then high, and 0 is a latch that changes nothing. A non-latch command resets that counter's write and read byte toggles.
- R8: A count write in mode 1 sets the base to {0x00, data}, in mode 2 to {data, 0x00}, and in mode 3 alternately fills the low and then the high byte. A count write to a counter that has never received a non-latch command is ignored.
- R9: A counter shadow read returns the base low byte in mode 0 or 1 and the high byte in mode 2. In mode 3 it alternates low and high on successive claimed reads, using a separate toggle for each counter.
- R10: After reset, every shadow byte reads 0 and every counter's read toggle points at the low byte.
- R11: The master and slave controllers keep independent shadows and independent sequence state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| shadow_en | input | 1 | Enables shadow readback |
| shadow_hit | output | 1 | Read claimed by this unit |
| shadow_rdata | output | 8 | Shadow read data |

## Verification
The bench builds the unit with its default parameters: a 16-bit address, 8-bit data, three counters, and decode tags 0x001, 0x005 and 0x002. With these, every counter and both controllers are reachable. The random addresses fill the ignored address bits with random values, so partial decoding is exercised on every access. Random write data often starts setup sequences part-way through other traffic, which brings sequence restarts, skipped cascade and fourth words, and mixed timer access modes within reach. Directed cases pin down exact byte layouts and the toggle resets.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ICW2 = 2'd1,
    SEQ_ICW3 = 2'd2,
    SEQ_ICW4 = 2'd3
  } icw_seq_e;

  typedef enum logic [1:0] {
    RW_LATCH = 2'd0,
    RW_LO    = 2'd1,
    RW_HI    = 2'd2,
    RW_LOHI  = 2'd3
  } rw_mode_e;

  typedef struct packed {
    logic poll;
    logic ris;
    logic smm;
    logic rot;
    logic sfnm;
    logic aeoi;
    logic ltim;
  } pic_fields_t;
endpackage

// File: rtl/lsu_pic_shadow.sv
module lsu_pic_shadow
  import lsu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int VEC_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_even,
  input  logic              wr_odd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctl_byte,
  output logic [DATA_W-1:0] mask_byte
);
  localparam int VEC_LSB = DATA_W - VEC_W;

  icw_seq_e          seq_q;
  logic              sngl_q;
  logic              ic4_q;
  pic_fields_t       f_q;
  logic [VEC_W-1:0]  vec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q  <= SEQ_IDLE;
      sngl_q <= 1'b0;
      ic4_q  <= 1'b0;
      f_q    <= '0;
      vec_q  <= '0;
    end else if (wr_even) begin
      if (wdata[4]) begin
        f_q.ltim <= wdata[3];
        sngl_q   <= wdata[1];
        ic4_q    <= wdata[0];
        seq_q    <= SEQ_ICW2;
      end else if (!wdata[3]) begin
        f_q.rot <= wdata[7];
      end else begin
        f_q.poll <= wdata[2];
        f_q.ris  <= wdata[0];
        if (wdata[6]) f_q.smm <= wdata[5];
      end
    end else if (wr_odd) begin
      case (seq_q)
        SEQ_ICW2: begin
          vec_q <= wdata[DATA_W-1:VEC_LSB];
          seq_q <= !sngl_q ? SEQ_ICW3 : (ic4_q ? SEQ_ICW4 : SEQ_IDLE);
        end
        SEQ_ICW3: seq_q <= ic4_q ? SEQ_ICW4 : SEQ_IDLE;
        SEQ_ICW4: begin
          f_q.aeoi <= wdata[1];
          f_q.sfnm <= wdata[4];
          seq_q    <= SEQ_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign ctl_byte  = {1'b0, f_q.poll, f_q.ris, f_q.smm, f_q.rot,
                      f_q.sfnm, f_q.aeoi, f_q.ltim};
  assign mask_byte = {{VEC_LSB{1'b0}}, vec_q};

  // Setup word always restarts the sequence (R4)
  assert_icw1_restart_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_even && wdata[4]) |=> (seq_q == SEQ_ICW2));

  // Plain mask writes do not touch the vector copy (R6)
  assert_mask_write_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_odd && !wr_even && seq_q == SEQ_IDLE) |=> $stable(vec_q));

  // Special-mask held unless its enable bit is set (R5)
  assert_smm_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_even && !wdata[4] && wdata[3] && !wdata[6]) |=> $stable(f_q.smm));
endmodule

// File: rtl/lsu_pit_counter.sv
module lsu_pit_counter
  import lsu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [1:0]        cmd_rw,
  input  logic              cnt_wr,
  input  logic              cnt_rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int COUNT_W = 2 * DATA_W;

  rw_mode_e           mode_q;
  logic [COUNT_W-1:0] base_q;
  logic               wtog_q;
  logic               rtog_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= RW_LATCH;
      base_q <= '0;
      wtog_q <= 1'b0;
      rtog_q <= 1'b0;
    end else if (cmd_wr) begin
      mode_q <= rw_mode_e'(cmd_rw);
      wtog_q <= 1'b0;
      rtog_q <= 1'b0;
    end else begin
      if (cnt_wr) begin
        case (mode_q)
          RW_LO: base_q <= {{DATA_W{1'b0}}, wdata};
          RW_HI: base_q <= {wdata, {DATA_W{1'b0}}};
          RW_LOHI: begin
            if (wtog_q) base_q[COUNT_W-1:DATA_W] <= wdata;
            else        base_q[DATA_W-1:0]       <= wdata;
            wtog_q <= ~wtog_q;
          end
          default: ;
        endcase
      end
      if (cnt_rd && mode_q == RW_LOHI) rtog_q <= ~rtog_q;
    end
  end

  always_comb begin
    case (mode_q)
      RW_HI:   rdata = base_q[COUNT_W-1:DATA_W];
      RW_LOHI: rdata = rtog_q ? base_q[COUNT_W-1:DATA_W] : base_q[DATA_W-1:0];
      default: rdata = base_q[DATA_W-1:0];
    endcase
  end

  // Two-byte reads alternate (R9)
  assert_read_toggle_R9: assert property (@(posedge clk) disable iff (rst)
    (cnt_rd && !cmd_wr && mode_q == RW_LOHI) |=> (rtog_q != $past(rtog_q)));

  // A new command resets both toggles (R7)
  assert_cmd_resets_toggles_R7: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |=> (!rtog_q && !wtog_q));

  // Base count moves only on a count write (R8)
  assert_base_only_on_write_R8: assert property (@(posedge clk) disable iff (rst)
    (!cnt_wr) |=> $stable(base_q));
endmodule

// File: rtl/lsu_pit_shadow.sv
module lsu_pit_shadow #(
  parameter int DATA_W  = 8,
  parameter int NUM_CNT = 3,
  parameter int SEL_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [SEL_W-1:0] CMD_SEL = SEL_W'(NUM_CNT);

  logic [DATA_W-1:0] cnt_rdata [NUM_CNT];
  logic              is_cmd;
  logic              rw_nonzero;

  assign is_cmd     = wr && (sel == CMD_SEL);
  assign rw_nonzero = |wdata[5:4];

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic cmd_hit;
    assign cmd_hit = is_cmd && rw_nonzero && (wdata[7:6] == 2'(i));

    lsu_pit_counter #(.DATA_W(DATA_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .cmd_wr (cmd_hit),
      .cmd_rw (wdata[5:4]),
      .cnt_wr (wr && sel == SEL_W'(i)),
      .cnt_rd (rd && sel == SEL_W'(i)),
      .wdata  (wdata),
      .rdata  (cnt_rdata[i])
    );
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (sel == SEL_W'(i)) rdata = cnt_rdata[i];
  end
endmodule

// File: rtl/legacy_shadow_unit.sv
module legacy_shadow_unit #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int DEC_LSB = 5,
  parameter int NUM_CNT = 3,
  parameter logic [ADDR_W-DEC_LSB-1:0] MASTER_TAG = 'h001,
  parameter logic [ADDR_W-DEC_LSB-1:0] SLAVE_TAG  = 'h005,
  parameter logic [ADDR_W-DEC_LSB-1:0] TIMER_TAG  = 'h002
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  input  logic              shadow_en,
  output logic              shadow_hit,
  output logic [7:0]        shadow_rdata
);
  localparam int TAG_W   = ADDR_W - DEC_LSB;
  localparam int NUM_PIC = 2;
  localparam int SEL_W   = $clog2(NUM_CNT + 1);
  localparam logic [TAG_W-1:0] PIC_TAG [NUM_PIC] = '{MASTER_TAG, SLAVE_TAG};
  localparam logic [SEL_W-1:0] CMD_SEL = SEL_W'(NUM_CNT);

  logic [TAG_W-1:0]  tag;
  logic [SEL_W-1:0]  tsel;
  logic [NUM_PIC-1:0] pic_sel;
  logic              tmr_sel;
  logic              rd_q;
  logic [DATA_W-1:0] pic_ctl  [NUM_PIC];
  logic [DATA_W-1:0] pic_mask [NUM_PIC];
  logic [DATA_W-1:0] pit_rdata;

  assign tag     = io_addr[ADDR_W-1:DEC_LSB];
  assign tsel    = io_addr[SEL_W-1:0];
  assign tmr_sel = (tag == TIMER_TAG);
  assign rd_q    = io_rd && shadow_en;

  for (genvar g = 0; g < NUM_PIC; g++) begin : g_pic
    assign pic_sel[g] = (tag == PIC_TAG[g]);

    lsu_pic_shadow #(.DATA_W(DATA_W)) u_pic (
      .clk       (clk),
      .rst       (rst),
      .wr_even   (io_wr && pic_sel[g] && !io_addr[0]),
      .wr_odd    (io_wr && pic_sel[g] &&  io_addr[0]),
      .wdata     (io_wdata),
      .ctl_byte  (pic_ctl[g]),
      .mask_byte (pic_mask[g])
    );
  end

  lsu_pit_shadow #(.DATA_W(DATA_W), .NUM_CNT(NUM_CNT), .SEL_W(SEL_W)) u_pit (
    .clk   (clk),
    .rst   (rst),
    .wr    (io_wr && tmr_sel),
    .rd    (rd_q && tmr_sel),
    .sel   (tsel),
    .wdata (io_wdata),
    .rdata (pit_rdata)
  );

  assign shadow_hit = rd_q && ((|pic_sel) || (tmr_sel && tsel != CMD_SEL));

  always_comb begin
    shadow_rdata = '0;
    if (shadow_hit) begin
      for (int g = 0; g < NUM_PIC; g++)
        if (pic_sel[g]) shadow_rdata = io_addr[0] ? pic_mask[g] : pic_ctl[g];
      if (tmr_sel) shadow_rdata = pit_rdata;
    end
  end

  // Never claim a read while readback is disabled (R1)
  assert_no_claim_disabled_R1: assert property (@(posedge clk) disable iff (rst)
    !shadow_en |-> !shadow_hit);

  // Timer command port is never claimed (R1)
  assert_cmd_port_unclaimed_R1: assert property (@(posedge clk) disable iff (rst)
    (tmr_sel && tsel == CMD_SEL) |-> !shadow_hit);

  // Unclaimed cycles drive zero data (R1)
  assert_idle_data_zero_R1: assert property (@(posedge clk) disable iff (rst)
    !shadow_hit |-> (shadow_rdata == '0));
endmodule

// File: tb/legacy_shadow_unit_test.sv
module legacy_shadow_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] io_addr;
  logic        io_rd, io_wr;
  logic [7:0]  io_wdata;
  logic        shadow_en;
  logic        shadow_hit;
  logic [7:0]  shadow_rdata;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  legacy_shadow_unit uut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .shadow_en(shadow_en), .shadow_hit(shadow_hit),
    .shadow_rdata(shadow_rdata)
  );

  // Reference model state
  logic [7:0]  m_ctl [2];
  logic [4:0]  m_vec [2];
  int          m_seq [2];
  bit          m_sngl [2], m_ic4 [2];
  logic [1:0]  m_mode [3];
  logic [15:0] m_base [3];
  bit          m_wt [3], m_rt [3];

  function automatic int pic_of(input logic [15:0] a);
    if (a[15:5] == 11'h001) return 0;
    if (a[15:5] == 11'h005) return 1;
    return -1;
  endfunction

  function automatic bit is_tmr(input logic [15:0] a);
    return a[15:5] == 11'h002;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_ctl[i] = 0; m_vec[i] = 0; m_seq[i] = 0; m_sngl[i] = 0; m_ic4[i] = 0;
    end
    for (int i = 0; i < 3; i++) begin
      m_mode[i] = 0; m_base[i] = 0; m_wt[i] = 0; m_rt[i] = 0;
    end
  endtask

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    int p = pic_of(a);
    if (p >= 0) begin
      if (!a[0]) begin
        if (d[4]) begin
          m_ctl[p][0] = d[3]; m_sngl[p] = d[1]; m_ic4[p] = d[0]; m_seq[p] = 1;
        end else if (!d[3]) m_ctl[p][3] = d[7];
        else begin
          m_ctl[p][6] = d[2]; m_ctl[p][5] = d[0];
          if (d[6]) m_ctl[p][4] = d[5];
        end
      end else begin
        case (m_seq[p])
          1: begin m_vec[p] = d[7:3]; m_seq[p] = !m_sngl[p] ? 2 : (m_ic4[p] ? 3 : 0); end
          2: m_seq[p] = m_ic4[p] ? 3 : 0;
          3: begin m_ctl[p][1] = d[1]; m_ctl[p][2] = d[4]; m_seq[p] = 0; end
          default: ;
        endcase
      end
    end else if (is_tmr(a)) begin
      int s = a[1:0];
      if (s == 3) begin
        int c = d[7:6];
        if (c < 3 && d[5:4] != 0) begin
          m_mode[c] = d[5:4]; m_wt[c] = 0; m_rt[c] = 0;
        end
      end else begin
        case (m_mode[s])
          2'd1: m_base[s] = {8'h00, d};
          2'd2: m_base[s] = {d, 8'h00};
          2'd3: begin
            if (m_wt[s]) m_base[s][15:8] = d; else m_base[s][7:0] = d;
            m_wt[s] = !m_wt[s];
          end
          default: ;
        endcase
      end
    end
  endtask

  function automatic void model_expect(input logic [15:0] a, input bit en,
                                       output bit hit, output logic [7:0] dat);
    int p = pic_of(a);
    hit = 0; dat = 0;
    if (!en) return;
    if (p >= 0) begin
      hit = 1;
      dat = a[0] ? {3'b000, m_vec[p]} : m_ctl[p];
    end else if (is_tmr(a) && a[1:0] != 2'd3) begin
      int s = a[1:0];
      hit = 1;
      case (m_mode[s])
        2'd2: dat = m_base[s][15:8];
        2'd3: dat = m_rt[s] ? m_base[s][15:8] : m_base[s][7:0];
        default: dat = m_base[s][7:0];
      endcase
    end
  endfunction

  task automatic check(input bit ok, input string req, input logic [8:0] act,
                       input logic [8:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h time=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_read(input logic [15:0] a, input bit en, input string req);
    bit ehit; logic [7:0] edat;
    @(negedge clk);
    io_addr = a; shadow_en = en; io_rd = 1'b1;
    #2;
    model_expect(a, en, ehit, edat);
    check(shadow_hit === ehit && shadow_rdata === edat, req,
          {shadow_hit, shadow_rdata}, {ehit, edat});
    @(negedge clk);
    io_rd = 1'b0; shadow_en = 1'b1;
    if (ehit && is_tmr(a) && m_mode[a[1:0]] == 2'd3) m_rt[a[1:0]] = !m_rt[a[1:0]];
  endtask

  // Check a single expected byte directly, independent of model
  task automatic read_exp(input logic [15:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    io_addr = a; shadow_en = 1'b1; io_rd = 1'b1;
    #2;
    check(shadow_hit === 1'b1 && shadow_rdata === exp, req,
          {shadow_hit, shadow_rdata}, {1'b1, exp});
    @(negedge clk);
    io_rd = 1'b0;
    if (is_tmr(a) && m_mode[a[1:0]] == 2'd3) m_rt[a[1:0]] = !m_rt[a[1:0]];
  endtask

  function automatic logic [15:0] rand_addr(input int kind);
    logic [15:0] r = 16'($urandom);
    case (kind)
      0: return {8'h00, 3'b001, r[4:0]};
      1: return {8'h00, 3'b101, r[4:0]};
      2: return {8'h00, 3'b010, r[4:0]};
      default: return r[0] ? {8'h00, 3'b011, r[4:0]} : {8'h10, 3'b001, r[4:0]};
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; io_addr = 0; io_rd = 0; io_wr = 0; io_wdata = 0; shadow_en = 1'b1;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R10: reset state
    foreach (m_ctl[i]) ;
    read_exp(16'h0020, 8'h00, "R10");
    read_exp(16'h0021, 8'h00, "R10");
    read_exp(16'h00A0, 8'h00, "R10");
    read_exp(16'h00A1, 8'h00, "R10");
    read_exp(16'h0040, 8'h00, "R10");
    read_exp(16'h0042, 8'h00, "R10");

    // R1: disabled reads, command port, foreign address
    do_read(16'h0020, 1'b0, "R1");
    do_read(16'h0043, 1'b1, "R1");
    do_read(16'h1020, 1'b1, "R1");

    // R4: master full sequence, with shadow disabled during writes (R2)
    shadow_en = 1'b0;
    do_write(16'h0020, 8'h19);
    do_write(16'h0021, 8'h08);
    do_write(16'h003F, 8'h04);
    do_write(16'h0021, 8'h13);
    shadow_en = 1'b1;
    read_exp(16'h0020, 8'h07, "R4");
    read_exp(16'h003F, 8'h01, "R4");
    read_exp(16'h002E, 8'h07, "R2");
    // R6: plain mask write ignored
    do_write(16'h0021, 8'hFF);
    read_exp(16'h0021, 8'h01, "R6");
    // R5: OCW3 without enable, with enable, then OCW2
    do_write(16'h0020, 8'h0F);
    read_exp(16'h0020, 8'h67, "R5");
    do_write(16'h0020, 8'h68);
    read_exp(16'h0020, 8'h17, "R5");
    do_write(16'h0020, 8'hA0);
    read_exp(16'h0020, 8'h1F, "R3");
    // R11: slave single mode, skip cascade word
    do_write(16'h00A0, 8'h13);
    do_write(16'h00A1, 8'h70);
    do_write(16'h00A1, 8'h01);
    read_exp(16'h00A0, 8'h00, "R11");
    read_exp(16'h00A1, 8'h0E, "R11");
    read_exp(16'h0020, 8'h1F, "R11");

    // R8: count write before any command is ignored
    do_write(16'h0040, 8'h55);
    read_exp(16'h0040, 8'h00, "R8");
    // R7/R8/R9: two-byte mode counter 0
    do_write(16'h0043, 8'h34);
    do_write(16'h0040, 8'h34);
    do_write(16'h0040, 8'h12);
    read_exp(16'h0040, 8'h34, "R9");
    read_exp(16'h005C, 8'h12, "R9");
    read_exp(16'h0040, 8'h34, "R9");
    // R7: latch command changes nothing, toggle continues
    do_write(16'h0043, 8'h00);
    read_exp(16'h0040, 8'h12, "R7");
    read_exp(16'h0040, 8'h34, "R7");
    // R7: new command resets read toggle mid-pair
    do_write(16'h0043, 8'h30);
    read_exp(16'h0040, 8'h34, "R7");
    // R8: low-only and high-only modes
    do_write(16'h0043, 8'h90);
    do_write(16'h0042, 8'hAB);
    read_exp(16'h0042, 8'hAB, "R8");
    read_exp(16'h0042, 8'hAB, "R9");
    do_write(16'h0043, 8'h60);
    do_write(16'h0041, 8'hC3);
    read_exp(16'h0041, 8'hC3, "R8");
    // R7: select 3 touches no counter
    do_write(16'h0043, 8'hD4);
    read_exp(16'h0041, 8'hC3, "R7");

    // Constrained random mix
    for (int n = 0; n < 4000; n++) begin
      int kind = $urandom % 4;
      logic [15:0] a = rand_addr(kind);
      if ($urandom % 2) do_write(a, 8'($urandom));
      else begin
        bit en = ($urandom % 8) != 0;
        string req;
        if (!en || kind == 3) req = "R1";
        else if (kind == 2) req = "R9";
        else req = a[0] ? "R4" : "R3";
        do_read(a, en, req);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule